// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block steps a switching converter from power-on to regulation. It waits until the bias supply is above its power-on threshold and the shutdown pin has been released. It then holds the low-side driver off for a fixed settling interval, and after that for an overcurrent sampling phase whose length is set by the sampler. A short initialization gap follows. The error amplifier is then enabled and the soft-start ramp is launched. A status flag shows that the ramp has finished.

All timing is counted in ticks of an external slow timebase, and the tick counts are parameters. On silicon the settle interval is about 6.8 ms, the sampling phase takes between 0 and 3.4 ms, and the whole start-up takes up to about 17 ms. A simulation can use a handful of ticks instead. If the supply flag drops, the block returns to idle and tells the sampler to discard its held value. If the shutdown pin is pulled low after start, the sequence stalls and restarts from the settle interval once the pin is released.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the idle state that follows, every output is low except `ocp_clr`, which is high.
- R2: With `vcc_ok` high and `sd_release` low, the block waits with all outputs low, `ocp_clr` included. Ticks received while waiting are not counted.
- R3: One clock after `vcc_ok` has been seen high, the block is armed. The clock edge that samples `sd_release` high while armed starts the settle interval, and `lg_off` goes high on that edge.
- R4: `ocp_start` is a single-cycle pulse. It is high in the cycle after the clock edge that samples the SETTLE_TICKS-th tick of the settle interval, and `lg_off` stays high throughout.
- R5: During the sampling phase `lg_off` stays high, for any number of cycles, until `ocp_done` is sampled high. Ticks have no effect in this phase.
- R6: On the edge that samples `ocp_done`, `lg_off` falls and the initialization gap starts. The edge that samples the INIT_TICKS-th tick of the gap sets `ea_en` high and produces a single-cycle `ss_start` pulse.
- R7: `pgood` goes high on the edge that samples `ss_done` during the ramp. `pgood` and `ea_en` then stay high regardless of ticks.
- R8: A clock edge that samples `vcc_ok` low, in any state, returns the block to idle. Output values are as in R1.
- R9: A clock edge that samples `sd_release` low after start returns the block to the armed state, with all outputs low and `ocp_clr` low. A later release restarts the full settle interval.
- R10: `ocp_done` has no effect outside the sampling phase, and `ss_done` has no effect outside the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Supply above power-on threshold |
| sd_release | input | 1 | Shutdown pin above disable trip level |
| tick | input | 1 | One-cycle timebase pulse |
| ocp_done | input | 1 | Overcurrent sample finished |
| ss_done | input | 1 | Soft-start ramp finished |
| ocp_clr | output | 1 | Discard held overcurrent value |
| lg_off | output | 1 | Hold low-side driver off |
| ocp_start | output | 1 | Pulse: begin overcurrent sample |
| ea_en | output | 1 | Error amplifier enable |
| ss_start | output | 1 | Pulse: begin soft-start ramp |
| pgood | output | 1 | Ramp complete, regulating |

## Verification
The hardest case to reach is a phase boundary that lands exactly on a tick or a done flag, under a different tick spacing each time. An off-by-one in the tick count shows up only when the final counted tick comes right at the end of a phase. The stimulus sweeps the tick period and the sampler and ramp delays, including a done flag in the very first cycle of its phase. It also sends stray done flags and ticks in phases that must ignore them, then drops the shutdown and supply flags mid-sequence.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_BIAS,
        S_OCP,
        S_INIT,
        S_RAMP,
        S_REG
    } seq_state_t;

    typedef struct packed {
        seq_state_t state;
        logic       ocp_pulse;
        logic       ss_pulse;
    } seq_regs_t;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // last tick of the interval
    assign hit = tick && (cnt_q == lim - 1'b1);

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim);

endmodule

// File: rtl/pwr_seq_outdec.sv
module pwr_seq_outdec
    import pwr_seq_pkg::*;
(
    input  seq_state_t st,
    input  logic       ocp_pulse,
    input  logic       ss_pulse,
    output logic       ocp_clr,
    output logic       lg_off,
    output logic       ocp_start,
    output logic       ea_en,
    output logic       ss_start,
    output logic       pgood
);
    always_comb begin
        ocp_clr   = (st == S_IDLE);
        lg_off    = (st == S_BIAS) || (st == S_OCP);
        ocp_start = ocp_pulse;
        ea_en     = (st == S_RAMP) || (st == S_REG);
        ss_start  = ss_pulse;
        pgood     = (st == S_REG);
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_TICKS = 68,
    parameter int INIT_TICKS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic sd_release,
    input  logic tick,
    input  logic ocp_done,
    input  logic ss_done,
    output logic ocp_clr,
    output logic lg_off,
    output logic ocp_start,
    output logic ea_en,
    output logic ss_start,
    output logic pgood
);
    localparam int MAX_TICKS = (SETTLE_TICKS > INIT_TICKS) ? SETTLE_TICKS : INIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_TICKS);
    localparam logic [CNT_W-1:0] INIT_LIM   = CNT_W'(INIT_TICKS);

    seq_regs_t        r_d, r_q;
    logic             tmr_clr;
    logic             tmr_hit;
    logic [CNT_W-1:0] tmr_lim;
    logic             counting;

    assign tmr_lim  = (r_q.state == S_INIT) ? INIT_LIM : SETTLE_LIM;
    assign counting = (r_q.state == S_BIAS) || (r_q.state == S_INIT);

    pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick),
        .lim   (tmr_lim),
        .hit   (tmr_hit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            S_IDLE: if (vcc_ok)     r_d.state = S_ARM;
            S_ARM:  if (sd_release) r_d.state = S_BIAS;
            S_BIAS: if (tmr_hit)    r_d.state = S_OCP;
            S_OCP:  if (ocp_done)   r_d.state = S_INIT;
            S_INIT: if (tmr_hit)    r_d.state = S_RAMP;
            S_RAMP: if (ss_done)    r_d.state = S_REG;
            S_REG:  r_d.state = S_REG;
            default: r_d.state = S_IDLE;
        endcase
        if (!vcc_ok) begin
            r_d.state = S_IDLE;
        end else if (!sd_release && r_q.state != S_IDLE) begin
            r_d.state = S_ARM;
        end
        r_d.ocp_pulse = (r_d.state == S_OCP)  && (r_q.state != S_OCP);
        r_d.ss_pulse  = (r_d.state == S_RAMP) && (r_q.state != S_RAMP);
        tmr_clr       = !counting || (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, ocp_pulse: 1'b0, ss_pulse: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    pwr_seq_outdec u_outdec (
        .st        (r_q.state),
        .ocp_pulse (r_q.ocp_pulse),
        .ss_pulse  (r_q.ss_pulse),
        .ocp_clr   (ocp_clr),
        .lg_off    (lg_off),
        .ocp_start (ocp_start),
        .ea_en     (ea_en),
        .ss_start  (ss_start),
        .pgood     (pgood)
    );

    assert_ocp_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_start |=> !ocp_start);

    assert_ss_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |=> !ss_start);

    assert_lgoff_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lg_off) && $past(vcc_ok) && $past(sd_release)) |-> $past(ocp_done));

    assert_pgood_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(ss_done));

    assert_supply_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (ocp_clr && !lg_off && !ea_en && !pgood));

    assert_shutdown_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_release |=> (!lg_off && !ea_en && !pgood && !ocp_start));

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
    localparam int SETTLE = 3;
    localparam int INIT   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 1'b0, sd_release = 1'b0, tick = 1'b0, ocp_done = 1'b0, ss_done = 1'b0;
    logic ocp_clr, lg_off, ocp_start, ea_en, ss_start, pgood;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwr_seq_ctrl #(.SETTLE_TICKS(SETTLE), .INIT_TICKS(INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .sd_release(sd_release),
        .tick(tick), .ocp_done(ocp_done), .ss_done(ss_done),
        .ocp_clr(ocp_clr), .lg_off(lg_off), .ocp_start(ocp_start),
        .ea_en(ea_en), .ss_start(ss_start), .pgood(pgood)
    );

    // vector order: {ocp_clr, lg_off, ocp_start, ea_en, ss_start, pgood}
    localparam logic [5:0] V_IDLE  = 6'b100000;
    localparam logic [5:0] V_ARM   = 6'b000000;
    localparam logic [5:0] V_BIAS  = 6'b010000;
    localparam logic [5:0] V_OCP0  = 6'b011000;
    localparam logic [5:0] V_INIT  = 6'b000000;
    localparam logic [5:0] V_RAMP0 = 6'b000110;
    localparam logic [5:0] V_RAMP  = 6'b000100;
    localparam logic [5:0] V_REG   = 6'b000101;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {ocp_clr, lg_off, ocp_start, ea_en, ss_start, pgood};
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // from idle, through arming, into the start of the settle interval
    task automatic to_bias();
        vcc_ok = 1'b0; sd_release = 1'b0; tick = 1'b0; ocp_done = 1'b0; ss_done = 1'b0;
        step();
        check("R8", V_IDLE);
        vcc_ok = 1'b1;
        step();
        check("R2", V_ARM);
        tick = 1'b1;                       // R2: ticks while armed are not counted
        repeat (3) begin step(); check("R2", V_ARM); end
        tick = 1'b0;
        sd_release = 1'b1;
        step();
        check("R3", V_BIAS);
    endtask

    // count the settle interval with a tick every p cycles
    task automatic settle(input int p);
        for (int k = 0; k < SETTLE; k++) begin
            repeat (p - 1) begin step(); check("R4", V_BIAS); end
            tick = 1'b1;
            ocp_done = (k % 2 == 0);       // R10: ignored during settle
            step();
            tick = 1'b0; ocp_done = 1'b0;
            if (k < SETTLE - 1) check("R4", V_BIAS);
            else                check("R4", V_OCP0);
        end
    endtask

    task automatic full_run(input int p, input int d);
        to_bias();
        settle(p);
        for (int j = 0; j < d; j++) begin
            tick = j[0];
            step();
            check("R5", V_BIAS);
        end
        tick = 1'b0;
        ocp_done = 1'b1;
        step();
        ocp_done = 1'b0;
        check("R6", V_INIT);
        for (int k = 0; k < INIT; k++) begin
            ss_done = 1'b1;                // R10: ignored during the gap
            repeat (p - 1) begin step(); check("R6", V_INIT); end
            ss_done = 1'b0;
            tick = 1'b1;
            step();
            tick = 1'b0;
            if (k < INIT - 1) check("R6", V_INIT);
            else              check("R6", V_RAMP0);
        end
        for (int j = 0; j < d; j++) begin
            tick = 1'b1;
            step();
            check("R7", V_RAMP);
        end
        tick = 1'b0;
        ss_done = 1'b1;
        step();
        ss_done = 1'b0;
        check("R7", V_REG);
        tick = 1'b1;
        repeat (2) begin step(); check("R7", V_REG); end
        tick = 1'b0;
        if (d % 2 == 0) begin
            sd_release = 1'b0;
            step();
            check("R9", V_ARM);
            sd_release = 1'b1;
            step();
            check("R9", V_BIAS);
            settle(p);
        end else begin
            vcc_ok = 1'b0;
            step();
            check("R8", V_IDLE);
        end
    endtask

    initial begin
        vcc_ok = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", V_IDLE);
        vcc_ok = 1'b0;
        rst_n = 1'b1;
        step();
        check("R1", V_IDLE);

        for (int p = 1; p <= 4; p++) begin
            for (int d = 0; d <= 5; d++) begin
                full_run(p, d);
            end
        end

        // supply drop during settle
        to_bias();
        vcc_ok = 1'b0;
        step();
        check("R8", V_IDLE);

        // shutdown during sampling, then full restart
        to_bias();
        settle(2);
        sd_release = 1'b0;
        step();
        check("R9", V_ARM);
        ocp_done = 1'b1;                   // R10: ignored while armed
        step();
        check("R10", V_ARM);
        ocp_done = 1'b0;
        sd_release = 1'b1;
        step();
        check("R9", V_BIAS);
        settle(1);

        // supply drop during the ramp
        vcc_ok = 1'b1;
        ocp_done = 1'b1;
        step();
        ocp_done = 1'b0;
        check("R6", V_INIT);
        tick = 1'b1;
        repeat (INIT) step();
        tick = 1'b0;
        check("R6", V_RAMP0);
        vcc_ok = 1'b0;
        step();
        check("R8", V_IDLE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule